// File: doc/BRIEF.md
# Watchdog Timer with Shared Scaler

This block is a watchdog that advances on its own free-running tick input. That input keeps pulsing while the processor clock is halted, so the watchdog still counts during sleep. An 8-bit base counter overflows every 256 ticks. A single 7-bit scaler is shared between two uses, and one assignment bit chooses which. In one setting it follows the watchdog as a postscaler and stretches the time-out. In the other it sits in front of a general timer's clock source as a prescaler, and the watchdog then times out on every base overflow.

A time-out raises a one-cycle reset request while the device is awake. While the device is asleep it raises a one-cycle wake-up request instead. Either way it drops an active-low time-out flag. Software keeps the watchdog alive with a clear strobe. Entering sleep gives the same clear. Both strobes also zero the scaler, but only while the scaler belongs to the watchdog. The block runs on one always-on fabric clock. The tick and the timer source are enable pulses on that clock.

Top module: `wdt_shared_scaler`

## Requirements
- R1: With `wdt_en`=1 and `scl_to_tmr`=1, the time-out comes on exactly the 256th `wdt_tick` pulse after a clear. Cycles without a tick do not advance the count.
- R2: A time-out while `in_sleep`=0 gives `rst_req` high for exactly one cycle, visible after the clock edge that samples the final tick, and `wake_req` stays low.
- R3: A time-out while `in_sleep`=1 gives `wake_req` high for exactly one cycle instead, and `rst_req` stays low.
- R4: `to_n` is 1 after reset. Every time-out drives it to 0. It returns to 1 on `por_set` or `clr_wdt`, and `por_set` has the highest priority.
- R5: With `wdt_en`=0, neither request is ever raised, whatever the tick count.
- R6: With `scl_to_tmr`=0 and `ratio_sel`=k (k=0..7), the time-out comes on tick number 256·2^k after a clear.
- R7: With `scl_to_tmr`=1, `tmr_tick` pulses once per 2^`ratio_sel` `tmr_src` pulses. With `scl_to_tmr`=0, `tmr_tick` repeats `tmr_src` one cycle later.
- R8: `clr_wdt` or `sleep_cmd` zeroes the base counter, and zeroes the scaler when `scl_to_tmr`=0. A tick in the same cycle as a clear is discarded.
- R9: With `scl_to_tmr`=1, a clear neither resets the prescaler count nor changes the assignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| por_set | input | 1 | Power-on set of the time-out flag |
| wdt_tick | input | 1 | Watchdog tick enable pulse |
| tmr_src | input | 1 | General timer clock source pulse |
| wdt_en | input | 1 | Watchdog enable configuration bit |
| scl_to_tmr | input | 1 | Scaler assignment: 0 watchdog postscaler, 1 timer prescaler |
| ratio_sel | input | 3 | Scaler ratio code, divide by 2^code |
| clr_wdt | input | 1 | Clear-watchdog strobe |
| sleep_cmd | input | 1 | Sleep-entry strobe |
| in_sleep | input | 1 | Device is asleep |
| rst_req | output | 1 | One-cycle reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| to_n | output | 1 | Time-out flag, low after a time-out |
| tmr_tick | output | 1 | Scaled timer clock pulse |

## Verification
The watchdog is run into a time-out under all eight postscaler codes with a tick every cycle. A sparse tick stream is also used, which tells counting on ticks apart from counting on clocks. The prescaler is swept over all eight codes and its period is measured twice, which shows that the tap choice and the counter wrap are both correct. Clears are placed mid-count, on the same cycle as a tick, and while the scaler belongs to the timer. The measured distance to the next event shows whether the base counter and the scaler were cleared or kept. The sleep, disable and power-on-set patterns separate the reset route, the wake route and the flag handling.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    SCL_WDT = 1'b0,
    SCL_TMR = 1'b1
  } scl_asg_e;
endpackage

// File: rtl/wdt_base_cnt.sv
module wdt_base_cnt #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic en,
  input  logic clr,
  output logic ovf
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick && en) cnt <= cnt + 1'b1;
  end

  assign ovf = tick & en & ~clr & (cnt == {W{1'b1}});
endmodule

// File: rtl/wdt_scaler.sv
module wdt_scaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_in,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             evt_out
);
  localparam int TAPS = 1 << SEL_W;
  localparam int CW   = TAPS - 1;

  logic [CW-1:0]   cnt;
  logic [TAPS-1:0] tap_hit;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (evt_in) cnt <= cnt + 1'b1;
  end

  assign tap_hit[0] = 1'b1;
  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    assign tap_hit[k] = &cnt[k-1:0];
  end

  assign evt_out = evt_in & tap_hit[sel];
endmodule

// File: rtl/wdt_shared_scaler.sv
module wdt_shared_scaler #(
  parameter int BASE_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por_set,
  input  logic             wdt_tick,
  input  logic             tmr_src,
  input  logic             wdt_en,
  input  logic             scl_to_tmr,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             clr_wdt,
  input  logic             sleep_cmd,
  input  logic             in_sleep,
  output logic             rst_req,
  output logic             wake_req,
  output logic             to_n,
  output logic             tmr_tick
);
  import wdt_pkg::*;

  scl_asg_e asg;
  logic     clr_any, ovf, scl_in, scl_clr, scl_evt, timeout, tmr_evt;

  assign asg     = scl_asg_e'(scl_to_tmr);
  assign clr_any = clr_wdt | sleep_cmd;

  wdt_base_cnt #(.W(BASE_W)) u_base (
    .clk (clk), .rst (rst), .tick (wdt_tick), .en (wdt_en),
    .clr (clr_any), .ovf (ovf)
  );

  assign scl_in  = (asg == SCL_TMR) ? tmr_src : ovf;
  assign scl_clr = clr_any & (asg == SCL_WDT);

  wdt_scaler #(.SEL_W(SEL_W)) u_scl (
    .clk (clk), .rst (rst), .evt_in (scl_in), .clr (scl_clr),
    .sel (ratio_sel), .evt_out (scl_evt)
  );

  assign timeout = wdt_en & ((asg == SCL_TMR) ? ovf : scl_evt);
  assign tmr_evt = (asg == SCL_TMR) ? scl_evt : tmr_src;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      tmr_tick <= 1'b0;
    end else begin
      rst_req  <= timeout & ~in_sleep;
      wake_req <= timeout & in_sleep;
      tmr_tick <= tmr_evt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || por_set) to_n <= 1'b1;
    else if (timeout)   to_n <= 1'b0;
    else if (clr_wdt)   to_n <= 1'b1;
  end
endmodule

// File: rtl/wdt_shared_scaler_chk.sv
module wdt_shared_scaler_chk (
  input logic clk,
  input logic rst,
  input logic por_set,
  input logic wdt_en,
  input logic clr_wdt,
  input logic sleep_cmd,
  input logic in_sleep,
  input logic scl_to_tmr,
  input logic tmr_src,
  input logic rst_req,
  input logic wake_req,
  input logic to_n,
  input logic tmr_tick
);
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst) rst_req |=> !rst_req); // R2
  AST_RST_AWAKE: assert property (@(posedge clk) disable iff (rst) rst_req |-> !$past(in_sleep)); // R2
  AST_WAKE_ASLEEP: assert property (@(posedge clk) disable iff (rst) wake_req |-> $past(in_sleep)); // R3
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (rst) wake_req |=> !wake_req); // R3
  AST_TO_DROPS: assert property (@(posedge clk) disable iff (rst) (rst_req || wake_req) && !$past(por_set) |-> !to_n); // R4
  AST_CLR_SETS_TO: assert property (@(posedge clk) disable iff (rst) clr_wdt |=> to_n); // R4
  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (rst) !wdt_en |=> !(rst_req || wake_req)); // R5
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst) !scl_to_tmr |=> tmr_tick == $past(tmr_src)); // R7
  AST_CLR_BLOCKS: assert property (@(posedge clk) disable iff (rst) (clr_wdt || sleep_cmd) |=> !(rst_req || wake_req)); // R8
endmodule

bind wdt_shared_scaler wdt_shared_scaler_chk u_chk (.*);

// File: tb/wdt_shared_scaler_bench.sv
`timescale 1ns/1ps
module wdt_shared_scaler_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por_set = 0, wdt_tick = 0, tmr_src = 0, wdt_en = 1, scl_to_tmr = 0;
  logic [2:0] ratio_sel = 0;
  logic clr_wdt = 0, sleep_cmd = 0, in_sleep = 0;
  logic rst_req, wake_req, to_n, tmr_tick;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdt_shared_scaler u_wdt_shared_scaler (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_clear();
    clr_wdt = 1; wdt_tick = 0; tmr_src = 0;
    @(negedge clk);
    clr_wdt = 0;
  endtask

  // ticks until a request appears; n = limit+1 if none
  task automatic run_wdt(input int limit, input int gap, output int n, output bit wake);
    bit found = 0;
    n = 0; wake = 0;
    while (!found && n < limit) begin
      wdt_tick = 1;
      @(negedge clk);
      n++;
      if (rst_req || wake_req) begin found = 1; wake = wake_req; end
      wdt_tick = 0;
      for (int g = 0; g < gap && !found; g++) begin
        @(negedge clk);
        if (rst_req || wake_req) begin found = 1; wake = wake_req; end
      end
    end
    wdt_tick = 0;
    if (!found) n = limit + 1;
  endtask

  task automatic run_tmr(input int limit, output int n);
    bit found = 0;
    n = 0;
    while (!found && n < limit) begin
      tmr_src = 1;
      @(negedge clk);
      n++;
      if (tmr_tick) found = 1;
    end
    tmr_src = 0;
    if (!found) n = limit + 1;
  endtask

  task automatic zero_scaler();
    scl_to_tmr = 0;
    do_clear();
    scl_to_tmr = 1;
  endtask

  initial begin
    int n;
    bit w;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(to_n == 1, "R4 reset to_n", to_n, 1);
    chk(rst_req == 0 && wake_req == 0, "R2 reset requests", rst_req + wake_req, 0);
    chk(tmr_tick == 0, "R7 reset tmr_tick", tmr_tick, 0);

    // R6 postscaler sweep
    scl_to_tmr = 0;
    for (int s = 0; s < 8; s++) begin
      ratio_sel = 3'(s);
      do_clear();
      chk(to_n == 1, "R4 clear sets to_n", to_n, 1);
      run_wdt((256 << s) + 4, 0, n, w);
      chk(n == (256 << s), "R6 postscaler time-out tick", n, 256 << s);
      chk(!w, "R2 awake gives reset", w, 0);
      chk(to_n == 0, "R4 time-out clears to_n", to_n, 0);
      @(negedge clk);
      chk(rst_req == 0, "R2 reset request single cycle", rst_req, 0);
    end

    // R4 por_set
    por_set = 1; @(negedge clk); por_set = 0;
    chk(to_n == 1, "R4 por_set restores to_n", to_n, 1);

    // R1 timer-assigned, dense and sparse ticks
    scl_to_tmr = 1; ratio_sel = 3'd5;
    do_clear();
    run_wdt(300, 0, n, w);
    chk(n == 256, "R1 overflow time-out dense", n, 256);
    do_clear();
    run_wdt(300, 2, n, w);
    chk(n == 256, "R1 overflow time-out sparse", n, 256);

    // R3 sleep route
    in_sleep = 1;
    do_clear();
    run_wdt(300, 0, n, w);
    chk(n == 256 && w == 1, "R3 asleep gives wake", n, 256);
    chk(rst_req == 0, "R3 no reset while asleep", rst_req, 0);
    @(negedge clk);
    chk(wake_req == 0, "R3 wake request single cycle", wake_req, 0);
    in_sleep = 0;

    // R5 disabled
    wdt_en = 0;
    do_clear();
    run_wdt(600, 0, n, w);
    chk(n == 601, "R5 disabled timer-assigned", n, 601);
    scl_to_tmr = 0; ratio_sel = 0;
    do_clear();
    run_wdt(600, 0, n, w);
    chk(n == 601, "R5 disabled postscaler", n, 601);
    wdt_en = 1;

    // R8 sleep strobe clears base counter
    scl_to_tmr = 1;
    do_clear();
    run_wdt(200, 0, n, w);
    sleep_cmd = 1; @(negedge clk); sleep_cmd = 0;
    run_wdt(300, 0, n, w);
    chk(n == 256, "R8 sleep strobe clears count", n, 256);

    // R8 clear beats tick in same cycle
    do_clear();
    run_wdt(255, 0, n, w);
    wdt_tick = 1; clr_wdt = 1;
    @(negedge clk);
    wdt_tick = 0; clr_wdt = 0;
    chk(rst_req == 0 && wake_req == 0, "R8 clear suppresses time-out", rst_req, 0);
    run_wdt(300, 0, n, w);
    chk(n == 256, "R8 tick with clear discarded", n, 256);

    // R8 clear zeroes postscaler
    scl_to_tmr = 0; ratio_sel = 3'd1;
    do_clear();
    run_wdt(300, 0, n, w);
    chk(n == 301, "R6 no time-out before 512", n, 301);
    do_clear();
    run_wdt(600, 0, n, w);
    chk(n == 512, "R8 clear zeroes postscaler", n, 512);

    // R7 prescaler sweep, two periods each
    for (int s = 0; s < 8; s++) begin
      ratio_sel = 3'(s);
      zero_scaler();
      run_tmr(300, n);
      chk(n == (1 << s), "R7 prescaler first period", n, 1 << s);
      run_tmr(300, n);
      chk(n == (1 << s), "R7 prescaler second period", n, 1 << s);
    end

    // R7 pass-through when scaler is on the watchdog
    scl_to_tmr = 0;
    tmr_src = 1; @(negedge clk);
    chk(tmr_tick == 1, "R7 pass-through high", tmr_tick, 1);
    tmr_src = 0; @(negedge clk);
    chk(tmr_tick == 0, "R7 pass-through low", tmr_tick, 0);

    // R9 clear keeps prescaler count and assignment
    ratio_sel = 3'd2;
    zero_scaler();
    run_tmr(2, n);
    chk(n == 3, "R9 no tick after two sources", n, 3);
    do_clear();
    run_tmr(10, n);
    chk(n == 2, "R9 prescaler count kept over clear", n, 2);
    run_tmr(10, n);
    chk(n == 4, "R9 assignment kept over clear", n, 4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule